// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a memory-mapped watchdog for a processor subsystem. Software sets it up with one write to a control word. That write gives a 16-bit reload count, an enable, a choice between two expiry actions, and an optional slow-down prescaler. Once enabled, a down-counter runs from the reload value. If software does not service the watchdog in time, the counter runs out and the block either raises a one-clock reset request or sets a sticky interrupt line.

Servicing is guarded. The counter restarts only when two specific 16-bit values are written to the service register in the right order. A stray write, or a write of either value on its own, does not restart it. The control word is write-once after power-on reset, so a runaway program cannot switch the watchdog off, and an explicit decision to leave it off also stays in force. A read-only count register lets software see how much time remains.

The register bus carries a byte address, 32-bit write data, byte enables and separate write and read strobes. Read data is registered and appears in the clock after the read strobe.

Top module: `keyed_watchdog`

## Requirements
- R1: After synchronous reset, the control word (word address 0x04) reads 0xFFFF0000 and the count word (0x08) reads 0x0000FFFF. Both wd_reset_req and wd_irq are low.
- R2: The first write to the control word that has any byte enable set is accepted, one byte lane at a time. Bits 31:16 are the reload count, bit 2 is enable, bit 1 selects reset mode (1) or interrupt mode (0), and bit 0 enables the prescaler. The accepted write also loads the counter with the new reload count. From then on, bit 3 (the lock flag) reads 1.
- R3: Every control write after the accepted one is ignored, whether it tries to disable, enable or change the count.
- R4: With the prescaler off and enable set, the counter falls by one on every clock. With enable clear, the counter holds its value.
- R5: With the prescaler on, the counter falls by one once every 2^PRESCALE_W clocks. The prescaler is cleared by a control load or a service reload.
- R6: In reset mode, when a counter step finds the count at 1 or 0, wd_reset_req is high for exactly the next clock and the counter reloads. With reload count N and no prescaler, the pulse appears N clocks after the control write.
- R7: In interrupt mode, expiry sets wd_irq instead. wd_irq stays high until a completed service and never causes a wd_reset_req pulse.
- R8: A service is a write of 0x556C and then a write of 0xAA39 to bits 15:0 of word 0x0C. Completing it reloads the counter from the reload count and clears wd_irq. A count read issued in the next clock returns the full reload count.
- R9: Any write other than 0xAA39 right after 0x556C returns the key sequence to its start without reloading. This includes a repeated 0x556C. A write of 0xAA39 that does not follow 0x556C also does not reload.
- R10: A service-register write counts only when byte enables 1 and 0 are both set. Otherwise it does not affect the key sequence.
- R11: A read returns data in the clock after the read strobe. The count word is read-only, so writes to it change nothing.
- R12: If a service completes in the same clock in which the counter would expire, the service wins: the counter reloads and there is no reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for the write |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| wd_reset_req | output | 1 | One-clock reset request on expiry (reset mode) |
| wd_irq | output | 1 | Sticky expiry interrupt (interrupt mode) |

## Verification
The bench builds the block with PRESCALE_W = 3, so a prescaled step takes 8 clocks rather than 65536. A prescaled expiry can then be timed exactly within a few dozen clocks. Reload counts of 3 to 20 keep unprescaled expiries short. They also make it possible to place the final service key on the exact clock in which the counter would otherwise expire, which tests the priority rule between the two.

// File: rtl/wdog_pkg.sv
// Package: register layout, service keys and shared types of the keyed watchdog.
// Assumes a 32-bit register bus and a fixed 16-bit reload field.
package wdog_pkg;

    localparam int BUS_W      = 32;
    localparam int BE_W       = BUS_W / 8;
    localparam int CNT_W      = 16;

    // Word indices (byte address >> 2)
    localparam int REG_CTRL   = 1;
    localparam int REG_COUNT  = 2;
    localparam int REG_SVC    = 3;

    localparam logic [CNT_W-1:0] KEY_ARM  = 16'h556C;
    localparam logic [CNT_W-1:0] KEY_FIRE = 16'hAA39;
    localparam logic [CNT_W-1:0] CNT_POR  = 16'hFFFF;

    typedef enum logic {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic             enable;
        logic             rst_mode;
        logic             pre_en;
    } wd_ctrl_t;

endpackage

// File: rtl/wdog_regs.sv
// Register front end: decodes the bus, holds the write-once control word and
// its lock flag, and returns registered read data.
// Assumes word-aligned access; address bits 1:0 are not decoded.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [BE_W-1:0]   bus_be,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  cnt_value,
    output wd_ctrl_t          ctrl_q,
    output wd_ctrl_t          ctrl_next,
    output logic              ctrl_locked,
    output logic              ctrl_load,
    output logic              svc_wr,
    output logic [CNT_W-1:0]  svc_data
);

    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              wr_any;
    logic [BUS_W-1:0]  rd_word;
    logic              unused_lsbs;

    assign word        = bus_addr[ADDR_W-1:2];
    assign unused_lsbs = ^bus_addr[1:0];
    assign wr_any      = bus_wr && (|bus_be);

    // Control write is accepted only while the lock flag is clear.
    assign ctrl_load   = wr_any && (word == WORD_W'(REG_CTRL)) && !ctrl_locked;

    // Service write needs both low byte lanes.
    assign svc_wr      = wr_any && (word == WORD_W'(REG_SVC)) && (bus_be[1:0] == 2'b11);
    assign svc_data    = bus_wdata[CNT_W-1:0];

    // Merge enabled byte lanes of the write into the current control value.
    always_comb begin
        ctrl_next = ctrl_q;
        if (bus_be[3]) ctrl_next.reload[15:8] = bus_wdata[31:24];
        if (bus_be[2]) ctrl_next.reload[7:0]  = bus_wdata[23:16];
        if (bus_be[0]) begin
            ctrl_next.enable   = bus_wdata[2];
            ctrl_next.rst_mode = bus_wdata[1];
            ctrl_next.pre_en   = bus_wdata[0];
        end
    end

    // Hold the control word and set the lock on its first accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q      <= '{reload: CNT_POR, enable: 1'b0, rst_mode: 1'b0, pre_en: 1'b0};
            ctrl_locked <= 1'b0;
        end else if (ctrl_load) begin
            ctrl_q      <= ctrl_next;
            ctrl_locked <= 1'b1;
        end
    end

    // Select the word addressed by a read.
    always_comb begin
        if (word == WORD_W'(REG_CTRL)) begin
            rd_word = {ctrl_q.reload, 12'b0, ctrl_locked,
                       ctrl_q.enable, ctrl_q.rst_mode, ctrl_q.pre_en};
        end else if (word == WORD_W'(REG_COUNT)) begin
            rd_word = {{(BUS_W-CNT_W){1'b0}}, cnt_value};
        end else begin
            rd_word = '0;
        end
    end

    // Register read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_word;
        end
    end

endmodule

// File: rtl/wdog_key.sv
// Service key sequencer: tracks the ordered two-value key and flags a
// completed service for one clock. Any wrong value returns it to idle.
// Assumes svc_wr is already qualified by address and byte enables.
module wdog_key
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             svc_wr,
    input  logic [CNT_W-1:0] svc_data,
    output logic             svc_reload
);

    key_state_t state_q, state_d;

    // Next state and completion flag from the current key step.
    always_comb begin
        state_d    = state_q;
        svc_reload = 1'b0;
        if (svc_wr) begin
            case (state_q)
                KEY_IDLE:  state_d = (svc_data == KEY_ARM) ? KEY_ARMED : KEY_IDLE;
                KEY_ARMED: begin
                    state_d    = KEY_IDLE;
                    svc_reload = (svc_data == KEY_FIRE);
                end
                default:   state_d = KEY_IDLE;
            endcase
        end
    end

    // Key state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KEY_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/wdog_prescale.sv
// Prescaler: free-running divide-by-2^PRESCALE_W while run is high,
// emitting a one-clock tick on its last count. Clear restarts it at zero.
// Assumes PRESCALE_W >= 1.
module wdog_prescale #(
    parameter int PRESCALE_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);

    logic [PRESCALE_W-1:0] div_q;

    assign tick = run && (&div_q);

    // Advance the divider while running; clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)     div_q <= '0;
        else if (clear) div_q <= '0;
        else if (run)   div_q <= div_q + 1'b1;
    end

endmodule

// File: rtl/wdog_counter.sv
// Down-counter and expiry action: steps on each tick, reloads on control
// load, service or expiry, and drives the reset pulse or sticky interrupt.
// Assumes ctrl_load and svc_reload never occur in the same clock.
module wdog_counter
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             pre_en,
    input  logic             rst_mode,
    input  logic             ps_tick,
    input  logic             ctrl_load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             svc_reload,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wd_reset_req,
    output logic             wd_irq
);

    logic step;
    logic expire;

    assign step   = enable && (pre_en ? ps_tick : 1'b1);
    assign expire = step && (cnt_q <= CNT_W'(1)) && !svc_reload && !ctrl_load;

    // Counter: load, reload or step down.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= CNT_POR;
        else if (ctrl_load)             cnt_q <= load_val;
        else if (svc_reload || expire)  cnt_q <= reload_val;
        else if (step)                  cnt_q <= cnt_q - 1'b1;
    end

    // Expiry outputs: one-clock reset pulse or sticky interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_reset_req <= 1'b0;
            wd_irq       <= 1'b0;
        end else begin
            wd_reset_req <= expire && rst_mode;
            if (svc_reload)                 wd_irq <= 1'b0;
            else if (expire && !rst_mode)   wd_irq <= 1'b1;
        end
    end

endmodule

// File: rtl/keyed_watchdog.sv
// Top of the keyed-service watchdog: joins the register front end, key
// sequencer, prescaler and counter. Assumes a single clock and a
// synchronous active-low power-on reset.
module keyed_watchdog
    import wdog_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int PRESCALE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [3:0]        bus_be,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              wd_reset_req,
    output logic              wd_irq
);

    wd_ctrl_t         ctrl_q;
    wd_ctrl_t         ctrl_next;
    logic             ctl_locked;
    logic             ctl_load;
    logic             ctl_en;
    logic             ctl_mode;
    logic             ctl_pre;
    logic [CNT_W-1:0] reload_val;
    logic             svc_wr;
    logic [CNT_W-1:0] svc_data;
    logic             svc_reload;
    logic             ps_tick;
    logic [CNT_W-1:0] cnt_q;

    assign ctl_en     = ctrl_q.enable;
    assign ctl_mode   = ctrl_q.rst_mode;
    assign ctl_pre    = ctrl_q.pre_en;
    assign reload_val = ctrl_q.reload;

    wdog_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_be      (bus_be),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_rdata   (bus_rdata),
        .cnt_value   (cnt_q),
        .ctrl_q      (ctrl_q),
        .ctrl_next   (ctrl_next),
        .ctrl_locked (ctl_locked),
        .ctrl_load   (ctl_load),
        .svc_wr      (svc_wr),
        .svc_data    (svc_data)
    );

    wdog_key u_key (
        .clk        (clk),
        .rst_n      (rst_n),
        .svc_wr     (svc_wr),
        .svc_data   (svc_data),
        .svc_reload (svc_reload)
    );

    wdog_prescale #(.PRESCALE_W(PRESCALE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctl_en && ctl_pre),
        .clear (ctl_load || svc_reload),
        .tick  (ps_tick)
    );

    wdog_counter u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (ctl_en),
        .pre_en       (ctl_pre),
        .rst_mode     (ctl_mode),
        .ps_tick      (ps_tick),
        .ctrl_load    (ctl_load),
        .load_val     (ctrl_next.reload),
        .reload_val   (reload_val),
        .svc_reload   (svc_reload),
        .cnt_q        (cnt_q),
        .wd_reset_req (wd_reset_req),
        .wd_irq       (wd_irq)
    );

endmodule

// File: rtl/wdog_checker.sv
// Checker for the keyed watchdog: temporal properties on control lock,
// counting, service reload and expiry outputs. Bound into keyed_watchdog.
module wdog_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_en,
    input logic        ctl_mode,
    input logic        ctl_pre,
    input logic        ctl_locked,
    input logic        ctl_load,
    input logic        svc_reload,
    input logic [15:0] cnt_q,
    input logic [15:0] reload_val,
    input logic        wd_reset_req,
    input logic        wd_irq
);

    // R3: once locked, control fields and lock stay fixed
    p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_locked |=> ctl_locked && $stable(ctl_en) && $stable(ctl_mode) && $stable(ctl_pre));

    // R4: unprescaled enabled counter steps down by one
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_en && !ctl_pre && !svc_reload && cnt_q > 16'd1) |=> cnt_q == $past(cnt_q) - 16'd1);

    // R4: disabled counter holds
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en && !ctl_load && !svc_reload) |=> $stable(cnt_q));

    // R6: reset pulse only in reset mode
    p_rst_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wd_reset_req |-> ctl_mode);

    // R6: reset pulse lasts one clock when reload exceeds one
    p_rst_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_reset_req && reload_val > 16'd1) |=> !wd_reset_req);

    // R7: interrupt only rises in interrupt mode
    p_irq_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_irq) |-> !ctl_mode);

    // R7: interrupt is sticky until service
    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_irq && !svc_reload) |=> wd_irq);

    // R8: completed service reloads counter and clears interrupt
    p_svc_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        svc_reload |=> (cnt_q == $past(reload_val)) && !wd_irq);

    // R12: service in an expiry clock gives no reset pulse
    p_svc_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        svc_reload |=> !wd_reset_req);

endmodule

bind keyed_watchdog wdog_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_en       (ctl_en),
    .ctl_mode     (ctl_mode),
    .ctl_pre      (ctl_pre),
    .ctl_locked   (ctl_locked),
    .ctl_load     (ctl_load),
    .svc_reload   (svc_reload),
    .cnt_q        (cnt_q),
    .reload_val   (reload_val),
    .wd_reset_req (wd_reset_req),
    .wd_irq       (wd_irq)
);

// File: tb/keyed_watchdog_tb.sv
// Bench: behavioural reference model compared every clock, plus directed
// checks derived from the requirements.
module keyed_watchdog_tb;

    localparam int ADDR_W = 8;
    localparam int PRE_W  = 3;
    localparam int PDIV   = 1 << PRE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [3:0]        bus_be = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_rdata;
    logic              wd_reset_req;
    logic              wd_irq;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    int pulses = 0;

    // model state
    int m_cnt, m_rel, m_ps, m_rd;
    bit m_en, m_mode, m_pre, m_lock, m_key, m_irq, m_rr, m_live;
    int wword, nrel;
    bit wr_any, ctl_ld, svc, rl, tick, expv;

    keyed_watchdog #(.ADDR_W(ADDR_W), .PRESCALE_W(PRE_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_be       (bus_be),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_rdata    (bus_rdata),
        .wd_reset_req (wd_reset_req),
        .wd_irq       (wd_irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Reference model, evaluated on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 'hFFFF; m_rel = 'hFFFF; m_ps = 0; m_rd = 0;
            m_en = 0; m_mode = 0; m_pre = 0; m_lock = 0; m_key = 0;
            m_irq = 0; m_rr = 0; m_live = 1;
        end else begin
            wword = int'(bus_addr) >> 2;
            if (bus_rd)
                m_rd = (wword == 1) ? ((m_rel << 16) | (int'(m_lock) << 3) | (int'(m_en) << 2)
                                        | (int'(m_mode) << 1) | int'(m_pre))
                     : (wword == 2) ? m_cnt : 0;
            wr_any = bus_wr && (bus_be != 0);
            ctl_ld = wr_any && wword == 1 && !m_lock;
            svc    = wr_any && wword == 3 && bus_be[1:0] == 2'b11;
            rl = 0;
            if (svc) begin
                if (!m_key && bus_wdata[15:0] == 16'h556C) m_key = 1;
                else begin
                    if (m_key && bus_wdata[15:0] == 16'hAA39) rl = 1;
                    m_key = 0;
                end
            end
            tick = m_en && (!m_pre || m_ps == PDIV - 1);
            expv = tick && m_cnt <= 1 && !rl && !ctl_ld;
            m_rr = expv && m_mode;
            if (rl) m_irq = 0;
            else if (expv && !m_mode) m_irq = 1;
            if (ctl_ld || rl) m_ps = 0;
            else if (m_en && m_pre) m_ps = (m_ps + 1) % PDIV;
            if (ctl_ld) begin
                nrel = m_rel;
                if (bus_be[3]) nrel = (nrel & 'h00FF) | (int'(bus_wdata[31:24]) << 8);
                if (bus_be[2]) nrel = (nrel & 'hFF00) | int'(bus_wdata[23:16]);
                if (bus_be[0]) begin
                    m_en = bus_wdata[2]; m_mode = bus_wdata[1]; m_pre = bus_wdata[0];
                end
                m_rel = nrel; m_lock = 1; m_cnt = nrel;
            end else if (rl || expv) m_cnt = m_rel;
            else if (tick) m_cnt = m_cnt - 1;
        end
    end

    // Compare against the model away from the clock edge; count pulses.
    always @(negedge clk) begin
        cycles++;
        if (m_live) begin
            check("R11 rdata vs model", int'(bus_rdata), m_rd);
            check("R6 reset_req vs model", int'(wd_reset_req), int'(m_rr));
            check("R7 irq vs model", int'(wd_irq), int'(m_irq));
            if (wd_reset_req) pulses++;
        end
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input int addr, input int data, input logic [3:0] be);
        bus_addr = ADDR_W'(addr); bus_wdata = data; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic bus_read(input int addr, output int data);
        bus_addr = ADDR_W'(addr); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        data = int'(bus_rdata);
    endtask

    task automatic service();
        bus_write('h0C, 'h556C, 4'b0011);
        bus_write('h0C, 'hAA39, 4'b0011);
    endtask

    task automatic wait_reset_pulse(output int n);
        n = 0;
        while (!wd_reset_req && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int rd;
        int n;
        int p0;

        // Reset state
        do_reset();
        bus_read('h04, rd); check("R1 ctrl after reset", rd, 'hFFFF0000);
        bus_read('h08, rd); check("R1 count after reset", rd, 'h0000FFFF);
        check("R1 reset_req low", int'(wd_reset_req), 0);
        check("R1 irq low", int'(wd_irq), 0);
        bus_write('h08, 'h1234, 4'hF);
        repeat (5) @(negedge clk);
        bus_read('h08, rd); check("R11 count read-only / R4 disabled hold", rd, 'hFFFF);

        // Reset mode, no prescaler, reload 20
        bus_write('h04, 'h0014_0006, 4'hF);
        wait_reset_pulse(n);
        check("R6 pulse after N clocks", n, 20);
        @(negedge clk);
        check("R6 pulse lasts one clock", int'(wd_reset_req), 0);
        bus_read('h04, rd); check("R2 ctrl fields and lock", rd, 'h0014_000E);
        bus_write('h04, 'h0005_0000, 4'hF);
        bus_read('h04, rd); check("R3 second ctrl write ignored", rd, 'h0014_000E);

        service();
        bus_read('h08, rd); check("R8 service reloads", rd, 20);
        service();
        bus_write('h0C, 'h556C, 4'b0011);
        bus_write('h0C, 'h1234, 4'b0011);
        bus_write('h0C, 'hAA39, 4'b0011);
        bus_read('h08, rd); check("R9 wrong second key", rd, 17);
        service();
        bus_write('h0C, 'h556C, 4'b0011);
        bus_write('h0C, 'h556C, 4'b0011);
        bus_write('h0C, 'hAA39, 4'b0011);
        bus_read('h08, rd); check("R9 repeated first key", rd, 17);
        service();
        bus_write('h0C, 'hAA39, 4'b0011);
        bus_write('h0C, 'h556C, 4'b0011);
        bus_read('h08, rd); check("R9 reversed order", rd, 18);
        bus_write('h0C, 'h0000, 4'b0011);
        service();
        bus_write('h0C, 'h556C, 4'b0001);
        bus_write('h0C, 'hAA39, 4'b0011);
        bus_read('h08, rd); check("R10 partial byte enables", rd, 18);

        // Service on the expiry clock
        service();
        p0 = pulses;
        bus_write('h0C, 'h556C, 4'b0011);
        repeat (18) @(negedge clk);
        bus_write('h0C, 'hAA39, 4'b0011);
        bus_read('h08, rd); check("R12 service beats expiry: count", rd, 20);
        check("R12 service beats expiry: no pulse", pulses - p0, 0);

        // Interrupt mode, reload 5
        do_reset();
        p0 = pulses;
        bus_write('h04, 'h0005_0004, 4'hF);
        n = 0;
        while (!wd_irq && n < 200) begin @(negedge clk); n++; end
        check("R7 irq after N clocks", n, 5);
        repeat (10) @(negedge clk);
        check("R7 irq sticky", int'(wd_irq), 1);
        check("R7 no reset pulse", pulses - p0, 0);
        service();
        check("R7 R8 service clears irq", int'(wd_irq), 0);

        // Prescaled reset mode, reload 3
        do_reset();
        bus_write('h04, 'h0003_0007, 4'hF);
        wait_reset_pulse(n);
        check("R5 prescaled expiry", n, 3 * PDIV);

        // Written disabled, then enable attempt
        do_reset();
        p0 = pulses;
        bus_write('h04, 'h0004_0000, 4'hF);
        bus_write('h04, 'h0004_0006, 4'hF);
        repeat (20) @(negedge clk);
        bus_read('h04, rd); check("R3 disable is final", rd, 'h0004_0008);
        bus_read('h08, rd); check("R4 R2 disabled counter holds load", rd, 4);
        check("R3 no pulse while disabled", pulses - p0, 0);
        check("R3 no irq while disabled", int'(wd_irq), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule